// File: doc/BRIEF.md
# Bidirectional GPIO Port Pair with Direction Control

This block is a pair of memory-mapped general-purpose I/O ports on a byte-wide internal register bus: an 8-bit port A and a 3-bit port B. Every pin has an output data latch and a direction latch. The direction latch decides whether the pin drives its pad as a push-pull output or leaves the pad alone and acts as an input. The block also produces a per-pin pull-high enable for the pad cell. For port A only, it raises a wake-up request to a halted core.

A core writes the latches with single-cycle write strobes. It reads them back through a combinational read path that is gated by a read strobe. When a data register is read, input pins return the live pad level at the time of the read. Output pins return their latch, so read-modify-write sequences keep the driven values. A cold reset makes every pin an input with all latches set to one. A warm reset leaves the port registers as they are and clears only the pending wake-up.

Top module: `gpio_port_pair`

## Requirements
- R1: Register map on `addr_i`: 0x12 is port A data, 0x13 is port A direction, 0x14 is port B data, 0x15 is port B direction. A read of any other address returns 0. `rdata_o` is 0 whenever `rd_i` is low.
- R2: In a direction register, a bit of 1 makes the pin an input (`*_oe_o` bit low). A bit of 0 makes it an output (`*_oe_o` bit high) that drives its data latch on `*_out_o`. A write takes effect on the clock edge that samples it.
- R3: A read of a data register returns, in the same cycle, the pad level (`*_pad_i`) for each input bit and the data latch for each output bit. Pads are not latched.
- R4: A data latch changes only when its data address is written. It accepts writes while the pin is an input, and that value appears when the pin is later turned into an output.
- R5: A read of a direction register returns the direction latch.
- R6: While `rst_ni` is low, all port A data and direction bits are 1 and all port B data and direction bits are 1, so every pin is an input.
- R7: A pulse on `warm_rst_i` changes no data or direction latch, and it clears `wake_o`.
- R8: `*_pu_o[i]` is high exactly when `*_pu_opt_i[i]` is 1 and pin i is an input.
- R9: While `halt_i` is high, a port A pin that is an input with `pa_wake_opt_i[i]` set, and whose pad is sampled 1 on one clock edge and 0 on the next, sets `wake_o` from that second edge onward. `wake_o` then stays high until an edge where `halt_i` is low. Disabled pins, output pins and port B pins never set it.
- R10: In port B registers, bits 7..3 read as 0 and ignore writes. Only bits 2..0 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset; clears only the wake-up request |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pa_pad_i | input | 8 | Port A pad levels |
| pa_out_o | output | 8 | Port A output values |
| pa_oe_o | output | 8 | Port A output enables |
| pa_pu_opt_i | input | 8 | Port A pull-high option bits |
| pa_pu_o | output | 8 | Port A pull-high enables |
| pa_wake_opt_i | input | 8 | Port A wake-up option bits |
| pb_pad_i | input | 3 | Port B pad levels |
| pb_out_o | output | 3 | Port B output values |
| pb_oe_o | output | 3 | Port B output enables |
| pb_pu_opt_i | input | 3 | Port B pull-high option bits |
| pb_pu_o | output | 3 | Port B pull-high enables |
| halt_i | input | 1 | Core is halted |
| wake_o | output | 1 | Wake-up request |

## Verification
A corrupted direction latch shows at `*_oe_o` on the edge after the write. It also shows on the next data read as a pad/latch swap on that bit. A data latch that drifts or takes a stray write shows at `*_out_o` in the same cycle, with no read needed. A wrong pad-history bit in the wake detector shows at `wake_o` one edge after a falling pad, either as a missed or as a spurious request. The bench checks each of these at the first negative edge where the value is settled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] PA_DATA_ADDR = 8'h12;
  localparam logic [ADDR_W-1:0] PA_CTRL_ADDR = 8'h13;
  localparam logic [ADDR_W-1:0] PB_DATA_ADDR = 8'h14;
  localparam logic [ADDR_W-1:0] PB_CTRL_ADDR = 8'h15;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PA_DATA,
    SEL_PA_CTRL,
    SEL_PB_DATA,
    SEL_PB_CTRL
  } rd_sel_e;

  function automatic rd_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      PA_DATA_ADDR: return SEL_PA_DATA;
      PA_CTRL_ADDR: return SEL_PA_CTRL;
      PB_DATA_ADDR: return SEL_PB_DATA;
      PB_CTRL_ADDR: return SEL_PB_CTRL;
      default:      return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned W      = 8,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = '0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pad_i,
  input  logic [W-1:0]      pu_opt_i,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      oe_o,
  output logic [W-1:0]      pu_o,
  output logic [BUS_W-1:0]  data_rd_o,
  output logic [BUS_W-1:0]  ctrl_rd_o
);
  logic [W-1:0] data_q, ctrl_q, rd_bits;
  logic         data_we, ctrl_we;

  assign data_we = wr_i && (addr_i == DATA_ADDR);
  assign ctrl_we = wr_i && (addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '1;
      ctrl_q <= '1;
    end else begin
      if (data_we) data_q <= wdata_i;
      if (ctrl_we) ctrl_q <= wdata_i;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    // input bits see the pad, output bits see the latch
    assign rd_bits[i] = ctrl_q[i] ? pad_i[i] : data_q[i];
    assign pu_o[i]    = pu_opt_i[i] & ctrl_q[i];
    assign oe_o[i]    = ~ctrl_q[i];
  end

  assign out_o = data_q;

  always_comb begin
    data_rd_o          = '0;
    data_rd_o[W-1:0]   = rd_bits;
    ctrl_rd_o          = '0;
    ctrl_rd_o[W-1:0]   = ctrl_q;
  end
endmodule

// File: rtl/gpio_wake_det.sv
module gpio_wake_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         warm_rst_i,
  input  logic         halt_i,
  input  logic [W-1:0] pad_i,
  input  logic [W-1:0] arm_i,
  output logic         wake_o
);
  logic [W-1:0] prev_q, fall;
  logic         wake_q;

  assign fall = arm_i & prev_q & ~pad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      wake_q <= 1'b0;
    end else begin
      prev_q <= pad_i;
      if (warm_rst_i || !halt_i) wake_q <= 1'b0;
      else if (|fall)            wake_q <= 1'b1;
    end
  end

  assign wake_o = wake_q;
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
(
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  pa_data_i,
  input  logic [BUS_W-1:0]  pa_ctrl_i,
  input  logic [BUS_W-1:0]  pb_data_i,
  input  logic [BUS_W-1:0]  pb_ctrl_i,
  output logic [BUS_W-1:0]  rdata_o
);
  rd_sel_e sel;

  always_comb begin
    sel     = decode_addr(addr_i);
    rdata_o = '0;
    if (rd_i) begin
      case (sel)
        SEL_PA_DATA: rdata_o = pa_data_i;
        SEL_PA_CTRL: rdata_o = pa_ctrl_i;
        SEL_PB_DATA: rdata_o = pb_data_i;
        SEL_PB_CTRL: rdata_o = pb_ctrl_i;
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_pair.sv
module gpio_port_pair
  import gpio_pkg::*;
#(
  parameter int unsigned PA_W = 8,
  parameter int unsigned PB_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [PA_W-1:0]   pa_pad_i,
  output logic [PA_W-1:0]   pa_out_o,
  output logic [PA_W-1:0]   pa_oe_o,
  input  logic [PA_W-1:0]   pa_pu_opt_i,
  output logic [PA_W-1:0]   pa_pu_o,
  input  logic [PA_W-1:0]   pa_wake_opt_i,
  input  logic [PB_W-1:0]   pb_pad_i,
  output logic [PB_W-1:0]   pb_out_o,
  output logic [PB_W-1:0]   pb_oe_o,
  input  logic [PB_W-1:0]   pb_pu_opt_i,
  output logic [PB_W-1:0]   pb_pu_o,
  input  logic              halt_i,
  output logic              wake_o
);
  logic [BUS_W-1:0] pa_data_rd, pa_ctrl_rd, pb_data_rd, pb_ctrl_rd;
  logic [PA_W-1:0]  pa_arm;

  gpio_bank #(
    .W(PA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
    .DATA_ADDR(PA_DATA_ADDR), .CTRL_ADDR(PA_CTRL_ADDR)
  ) u_bank_a (
    .clk_i, .rst_ni, .wr_i, .addr_i,
    .wdata_i  (wdata_i[PA_W-1:0]),
    .pad_i    (pa_pad_i),
    .pu_opt_i (pa_pu_opt_i),
    .out_o    (pa_out_o),
    .oe_o     (pa_oe_o),
    .pu_o     (pa_pu_o),
    .data_rd_o(pa_data_rd),
    .ctrl_rd_o(pa_ctrl_rd)
  );

  gpio_bank #(
    .W(PB_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
    .DATA_ADDR(PB_DATA_ADDR), .CTRL_ADDR(PB_CTRL_ADDR)
  ) u_bank_b (
    .clk_i, .rst_ni, .wr_i, .addr_i,
    .wdata_i  (wdata_i[PB_W-1:0]),
    .pad_i    (pb_pad_i),
    .pu_opt_i (pb_pu_opt_i),
    .out_o    (pb_out_o),
    .oe_o     (pb_oe_o),
    .pu_o     (pb_pu_o),
    .data_rd_o(pb_data_rd),
    .ctrl_rd_o(pb_ctrl_rd)
  );

  // only enabled input pins of port A can wake the core
  assign pa_arm = pa_wake_opt_i & ~pa_oe_o;

  gpio_wake_det #(.W(PA_W)) u_wake (
    .clk_i, .rst_ni, .warm_rst_i, .halt_i,
    .pad_i (pa_pad_i),
    .arm_i (pa_arm),
    .wake_o
  );

  gpio_rd_mux u_rd_mux (
    .rd_i, .addr_i,
    .pa_data_i(pa_data_rd),
    .pa_ctrl_i(pa_ctrl_rd),
    .pb_data_i(pb_data_rd),
    .pb_ctrl_i(pb_ctrl_rd),
    .rdata_o
  );
endmodule

// File: rtl/gpio_port_pair_chk.sv
module gpio_port_pair_chk
  import gpio_pkg::*;
#(
  parameter int unsigned PA_W = 8,
  parameter int unsigned PB_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic [PA_W-1:0]   pa_pad_i,
  input logic [PA_W-1:0]   pa_out_o,
  input logic [PA_W-1:0]   pa_oe_o,
  input logic [PA_W-1:0]   pa_pu_o,
  input logic              halt_i,
  input logic              wake_o
);
  // R1
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);

  // R2
  dir_write_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == PA_CTRL_ADDR) |=> pa_oe_o == ~$past(wdata_i[PA_W-1:0]));

  // R3
  pa_read_mix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == PA_DATA_ADDR) |->
      rdata_o[PA_W-1:0] == ((pa_pad_i & ~pa_oe_o) | (pa_out_o & pa_oe_o)));

  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == PA_DATA_ADDR) |=> $stable(pa_out_o));

  // R8
  pull_only_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pa_pu_o & pa_oe_o) == '0);

  // R9
  wake_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_i |=> !wake_o);

  // R10
  pb_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == PB_DATA_ADDR || addr_i == PB_CTRL_ADDR)) |->
      (rdata_o >> PB_W) == '0);
endmodule

bind gpio_port_pair gpio_port_pair_chk #(.PA_W(PA_W), .PB_W(PB_W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i, .rdata_o,
  .pa_pad_i, .pa_out_o, .pa_oe_o, .pa_pu_o, .halt_i, .wake_o
);

// File: tb/gpio_port_pair_tb.sv
module gpio_port_pair_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       warm_rst_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [7:0] pa_pad_i = 8'hFF, pa_out_o, pa_oe_o, pa_pu_opt_i = '0, pa_pu_o, pa_wake_opt_i = '0;
  logic [2:0] pb_pad_i = 3'h7, pb_out_o, pb_oe_o, pb_pu_opt_i = '0, pb_pu_o;
  logic       halt_i = 1'b0, wake_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  gpio_port_pair u_dut (.*);

  // {port_b, dir, data, pad, expected read}
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 8'hFF, 8'h00, 8'hA5, 8'hA5},
    {1'b0, 8'h00, 8'h3C, 8'hFF, 8'h3C},
    {1'b0, 8'hF0, 8'h0F, 8'h00, 8'h0F},
    {1'b0, 8'h0F, 8'hF0, 8'h55, 8'hF5},
    {1'b1, 8'h07, 8'h00, 8'h02, 8'h02},
    {1'b1, 8'h00, 8'hFF, 8'h00, 8'h07},
    {1'b1, 8'h05, 8'h02, 8'h01, 8'h03},
    {1'b0, 8'hAA, 8'h55, 8'h00, 8'h55}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    #1 v = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    // R6 values while reset is held
    check("R6 pa_out", pa_out_o, 8'hFF);
    check("R6 pa_oe", pa_oe_o, 8'h00);
    check("R6 pb_out", {5'b0, pb_out_o}, 8'h07);
    check("R6 pb_oe", {5'b0, pb_oe_o}, 8'h00);
    rst_ni = 1'b1;
    rd_reg(8'h13, v); check("R6 pa dir read", v, 8'hFF);
    rd_reg(8'h15, v); check("R6 pb dir read", v, 8'h07);

    // R1 strobe gating and unmapped address
    @(negedge clk_i); addr_i = 8'h12; rd_i = 1'b0;
    #1 check("R1 no strobe", rdata_o, 8'h00);
    rd_reg(8'h20, v); check("R1 unmapped", v, 8'h00);

    foreach (VEC[k]) begin
      logic pb;
      logic [7:0] dir, dat, pad, exp;
      {pb, dir, dat, pad, exp} = VEC[k];
      wr_reg(pb ? 8'h15 : 8'h13, dir);
      wr_reg(pb ? 8'h14 : 8'h12, dat);
      if (pb) pb_pad_i = pad[2:0]; else pa_pad_i = pad;
      rd_reg(pb ? 8'h14 : 8'h12, v);
      check("R3 mixed read", v, exp);
      if (pb) begin
        check("R2 pb oe", {5'b0, pb_oe_o}, {5'b0, ~dir[2:0]});
        check("R2 pb out", {5'b0, pb_out_o}, {5'b0, dat[2:0]});
      end else begin
        check("R2 pa oe", pa_oe_o, ~dir);
        check("R2 pa out", pa_out_o, dat);
      end
    end
    rd_reg(8'h13, v); check("R5 pa dir read", v, 8'hAA);
    rd_reg(8'h15, v); check("R5 pb dir read", v, 8'h05);

    // R4 latch written while input, exposed when turned to output
    wr_reg(8'h13, 8'hFF);
    wr_reg(8'h12, 8'h5A);
    pa_pad_i = 8'h00;
    rd_reg(8'h12, v); check("R4 input reads pad", v, 8'h00);
    wr_reg(8'h13, 8'h00);
    rd_reg(8'h12, v); check("R4 latch exposed", v, 8'h5A);
    repeat (4) @(negedge clk_i);
    check("R4 latch held", pa_out_o, 8'h5A);

    // R10 port B upper bits
    wr_reg(8'h15, 8'h00);
    wr_reg(8'h14, 8'hFA);
    check("R10 pb out", {5'b0, pb_out_o}, 8'h02);
    rd_reg(8'h14, v); check("R10 pb data read", v, 8'h02);
    wr_reg(8'h15, 8'hF8);
    rd_reg(8'h15, v); check("R10 pb dir read", v, 8'h00);

    // R8 pull-high enables
    wr_reg(8'h13, 8'hF0);
    pa_pu_opt_i = 8'hFF;
    #1 check("R8 pa pull", pa_pu_o, 8'hF0);
    pa_pu_opt_i = 8'h0F;
    #1 check("R8 pa pull masked", pa_pu_o, 8'h00);
    wr_reg(8'h15, 8'h05);
    pb_pu_opt_i = 3'h7;
    #1 check("R8 pb pull", {5'b0, pb_pu_o}, 8'h05);

    // R7 warm reset keeps latches
    @(negedge clk_i); warm_rst_i = 1'b1;
    @(negedge clk_i); warm_rst_i = 1'b0;
    check("R7 data kept", pa_out_o, 8'h5A);
    rd_reg(8'h13, v); check("R7 dir kept", v, 8'hF0);

    // R9 wake-up
    wr_reg(8'h13, 8'hFF);
    pa_pad_i = 8'hFF; pa_wake_opt_i = 8'h01; halt_i = 1'b1;
    repeat (2) @(negedge clk_i);
    pa_pad_i = 8'hFD;
    @(negedge clk_i); check("R9 disabled pin", {7'b0, wake_o}, 8'h00);
    pa_pad_i = 8'hFF; @(negedge clk_i);
    pa_pad_i = 8'hFE;
    @(negedge clk_i); check("R9 wake set", {7'b0, wake_o}, 8'h01);
    repeat (3) @(negedge clk_i);
    check("R9 wake held", {7'b0, wake_o}, 8'h01);
    halt_i = 1'b0;
    @(negedge clk_i); check("R9 wake cleared", {7'b0, wake_o}, 8'h00);

    // R9 output pin cannot wake
    pa_pad_i = 8'hFF; wr_reg(8'h13, 8'hFE); halt_i = 1'b1;
    @(negedge clk_i); pa_pad_i = 8'hFE;
    @(negedge clk_i); check("R9 output pin", {7'b0, wake_o}, 8'h00);

    // R9 port B cannot wake
    pa_pad_i = 8'hFF; wr_reg(8'h13, 8'hFF); wr_reg(8'h15, 8'h07);
    pb_pad_i = 3'h7; @(negedge clk_i); pb_pad_i = 3'h0;
    @(negedge clk_i); check("R9 port B", {7'b0, wake_o}, 8'h00);

    // R9 fall while running does not wake later
    halt_i = 1'b0; @(negedge clk_i); pa_pad_i = 8'hFE;
    @(negedge clk_i); halt_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R9 fall while running", {7'b0, wake_o}, 8'h00);

    // R7 warm reset clears pending wake
    pa_pad_i = 8'hFF; @(negedge clk_i); pa_pad_i = 8'hFE;
    @(negedge clk_i); check("R7 wake before warm", {7'b0, wake_o}, 8'h01);
    warm_rst_i = 1'b1; @(negedge clk_i); warm_rst_i = 1'b0;
    check("R7 wake cleared", {7'b0, wake_o}, 8'h00);

    done = 1;
    summary();
    $finish;
  end
endmodule